// File: doc/BRIEF.md
# Dual-Space I2C Register Target

This block is an I2C target that answers two 7-bit bus addresses and turns bus transfers into single-cycle strobes on a register port. One address reaches a power-management register space and the other, fixed by default at 0x48, reaches a real-time-clock register space. The port carries a space select, an 8-bit register address, write data and a write strobe. Read data returns combinationally in the cycle of the read strobe. The bus side is two inputs, SCL and SDA, and one open-drain enable that pulls SDA low. Both inputs pass through two-flop synchronizers. The target never stretches the clock and supports only 7-bit addressing.

The two spaces take writes in different ways. On the clock space, the first byte after the address header is a register pointer. Every later byte is stored at the pointer, which then advances by one. On the power space, the bytes of a write alternate: a register address, then the data byte for that address, then another address, and so on. Each space has its own pointer. A read on either space first sets the pointer with a short write, then uses a repeated START to read one or more bytes from consecutive registers.

Top module: `dual_space_i2c_target`

## Requirements
- R1: The target ACKs an address header (pulls SDA low in the ninth clock) whose 7-bit address equals POWER_ADDR (default 0x1C) or RTC_ADDR (default 0x48). For any other address it leaves SDA released, produces no register strobe and drives nothing until the next START.
- R2: On the clock space (reg_space = 1), the first byte of a write loads the pointer. Each following byte gives one reg_wr pulse at the pointer, which then increments, so the bytes land at consecutive addresses.
- R3: On the power space (reg_space = 0), write bytes alternate address, data, address, data. Each data byte gives one reg_wr pulse at the address byte just before it, and the registers between two pairs are not written.
- R4: A STOP or a repeated START returns the write byte parity to expecting a pointer/address byte. An address byte left without its data writes nothing, and the next write begins with an address byte.
- R5: A read header returns the byte at the space's pointer, MSB first, and then one byte from each following register for every byte the controller ACKs. The pointer keeps its advanced value for the next read.
- R6: Every byte sent gives exactly one single-cycle reg_rd pulse, in the cycle that byte is loaded for transmit. An N-byte read ended by a controller NACK gives exactly N pulses, so a clear-on-read register (clock space status at 0x00) clears only once.
- R7: Every data byte written to either space is ACKed, and reg_rd and reg_wr are never high in the same cycle.
- R8: The two spaces keep separate pointers, so accesses on the power address never change where the next clock-space read starts.
- R9: After reset sda_oe is 0, no strobe is issued, and both pointers are 0x00, so a read with no pointer write starts at register 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| reg_wr | output | 1 | Single-cycle register write strobe |
| reg_rd | output | 1 | Single-cycle register read strobe |
| reg_space | output | 1 | 0 = power space, 1 = clock space |
| reg_addr | output | 8 | Register address for the strobe |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data, valid in the reg_rd cycle |

## Verification
The hardest case to reach from the pins is a power-space write that ends on an odd byte. The pair parity is then left at "expecting data", and only a STOP or a repeated START can restore it. The stimulus sends address, data, address and then closes the transfer, once with a STOP and once with a repeated START. It then checks that the next data byte lands at the newly sent address and not at the dangling one. Read strobes are counted against a register model that clears the clock-space status register when read. A second read of that register shows whether the strobe fired exactly once per delivered byte.

// File: rtl/dsit_pkg.sv
package dsit_pkg;

    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned CNT_W      = $clog2(BYTE_W + 1);
    localparam int unsigned NUM_SPACES = 2;

    typedef enum logic [2:0] {
        ST_IDLE,   // not addressed, wait for START
        ST_HDR,    // shifting in the address header
        ST_HACK,   // ninth clock of an accepted header
        ST_WRX,    // shifting in a write byte
        ST_WACK,   // ninth clock of a write byte
        ST_TX,     // shifting out a read byte
        ST_MACK    // ninth clock, controller acknowledge
    } dsit_state_e;

    typedef struct packed {
        dsit_state_e         st;
        logic [CNT_W-1:0]    bcnt;
        logic [BYTE_W-1:0]   sh;
        logic                oe;
        logic                ptr_ph;  // next write byte is a pointer/address
        logic                rtc;     // selected space
        logic                rnw;     // header direction
        logic                more;    // controller ACKed last read byte
    } dsit_ctl_t;

endpackage

// File: rtl/dsit_line_cond.sv
module dsit_line_cond #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_s,
    output logic start_det,
    output logic stop_det
);

    localparam int unsigned PIPE_W = SYNC_STAGES + 1;

    typedef struct packed {
        logic [PIPE_W-1:0] scl_p;
        logic [PIPE_W-1:0] sda_p;
    } lc_t;

    lc_t d, q;

    always_comb begin
        d       = q;
        d.scl_p = {q.scl_p[PIPE_W-2:0], scl_i};
        d.sda_p = {q.sda_p[PIPE_W-2:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{scl_p: '1, sda_p: '1};
        end else begin
            q <= d;
        end
    end

    logic scl_now, scl_old, sda_now, sda_old;

    always_comb begin
        scl_now   = q.scl_p[SYNC_STAGES-1];
        scl_old   = q.scl_p[SYNC_STAGES];
        sda_now   = q.sda_p[SYNC_STAGES-1];
        sda_old   = q.sda_p[SYNC_STAGES];
        scl_rise  = scl_now & ~scl_old;
        scl_fall  = ~scl_now & scl_old;
        sda_s     = sda_now;
        start_det = scl_now & scl_old & sda_old & ~sda_now;
        stop_det  = scl_now & scl_old & ~sda_old & sda_now;
    end

endmodule

// File: rtl/dsit_reg_ptr.sv
module dsit_reg_ptr #(
    parameter int unsigned AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [AW-1:0] ld_val,
    input  logic          inc,
    output logic [AW-1:0] ptr
);

    logic [AW-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (ld) begin
            ptr_d = ld_val;
        end else if (inc) begin
            ptr_d = ptr_q + AW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign ptr = ptr_q;

endmodule

// File: rtl/dual_space_i2c_target.sv
module dual_space_i2c_target
    import dsit_pkg::*;
#(
    parameter logic [6:0] POWER_ADDR  = 7'h1C,
    parameter logic [6:0] RTC_ADDR    = 7'h48,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic              reg_space,
    output logic [BYTE_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    input  logic [BYTE_W-1:0] reg_rdata
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    logic scl_rise_w, scl_fall_w, sda_w, start_w, stop_w;

    dsit_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise_w),
        .scl_fall  (scl_fall_w),
        .sda_s     (sda_w),
        .start_det (start_w),
        .stop_det  (stop_w)
    );

    dsit_ctl_t d, q;

    logic              ptr_ld, ptr_inc;
    logic              wr_s, rd_s;
    logic [BYTE_W-1:0] ptr_all [NUM_SPACES];

    // one pointer per register space
    for (genvar g = 0; g < NUM_SPACES; g++) begin : g_ptr
        dsit_reg_ptr #(.AW(BYTE_W)) u_ptr (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld     (ptr_ld  && (int'(q.rtc) == g)),
            .ld_val (q.sh),
            .inc    (ptr_inc && (int'(q.rtc) == g)),
            .ptr    (ptr_all[g])
        );
    end

    always_comb begin
        d       = q;
        wr_s    = 1'b0;
        rd_s    = 1'b0;
        ptr_ld  = 1'b0;
        ptr_inc = 1'b0;

        unique case (q.st)
            ST_IDLE: begin
                d.oe = 1'b0;
            end

            ST_HDR: begin
                if (scl_rise_w && (q.bcnt < FULL)) begin
                    d.sh   = {q.sh[BYTE_W-2:0], sda_w};
                    d.bcnt = q.bcnt + CNT_W'(1);
                end else if (scl_fall_w && (q.bcnt == FULL)) begin
                    d.bcnt = '0;
                    if (q.sh[BYTE_W-1:1] == POWER_ADDR || q.sh[BYTE_W-1:1] == RTC_ADDR) begin
                        d.st  = ST_HACK;
                        d.oe  = 1'b1;
                        d.rtc = (q.sh[BYTE_W-1:1] == RTC_ADDR);
                        d.rnw = q.sh[0];
                    end else begin
                        d.st = ST_IDLE;
                    end
                end
            end

            ST_HACK: begin
                if (scl_fall_w) begin
                    d.bcnt = '0;
                    if (q.rnw) begin
                        rd_s    = 1'b1;
                        ptr_inc = 1'b1;
                        d.sh    = reg_rdata;
                        d.oe    = ~reg_rdata[BYTE_W-1];
                        d.st    = ST_TX;
                    end else begin
                        d.oe = 1'b0;
                        d.st = ST_WRX;
                    end
                end
            end

            ST_WRX: begin
                if (scl_rise_w && (q.bcnt < FULL)) begin
                    d.sh   = {q.sh[BYTE_W-2:0], sda_w};
                    d.bcnt = q.bcnt + CNT_W'(1);
                end else if (scl_fall_w && (q.bcnt == FULL)) begin
                    d.bcnt = '0;
                    d.oe   = 1'b1;
                    d.st   = ST_WACK;
                    if (q.ptr_ph) begin
                        ptr_ld   = 1'b1;
                        d.ptr_ph = 1'b0;
                    end else begin
                        wr_s = 1'b1;
                        if (q.rtc) begin
                            ptr_inc = 1'b1;
                        end else begin
                            d.ptr_ph = 1'b1;
                        end
                    end
                end
            end

            ST_WACK: begin
                if (scl_fall_w) begin
                    d.oe = 1'b0;
                    d.st = ST_WRX;
                end
            end

            ST_TX: begin
                if (scl_rise_w && (q.bcnt < FULL)) begin
                    d.bcnt = q.bcnt + CNT_W'(1);
                end else if (scl_fall_w) begin
                    if (q.bcnt == FULL) begin
                        d.oe = 1'b0;
                        d.st = ST_MACK;
                    end else begin
                        d.sh = {q.sh[BYTE_W-2:0], 1'b0};
                        d.oe = ~q.sh[BYTE_W-2];
                    end
                end
            end

            ST_MACK: begin
                if (scl_rise_w) begin
                    d.more = ~sda_w;
                end else if (scl_fall_w) begin
                    d.bcnt = '0;
                    if (q.more) begin
                        rd_s    = 1'b1;
                        ptr_inc = 1'b1;
                        d.sh    = reg_rdata;
                        d.oe    = ~reg_rdata[BYTE_W-1];
                        d.st    = ST_TX;
                    end else begin
                        d.oe = 1'b0;
                        d.st = ST_IDLE;
                    end
                end
            end

            default: begin
                d.st = ST_IDLE;
                d.oe = 1'b0;
            end
        endcase

        // bus conditions override any byte activity
        if (start_w || stop_w) begin
            wr_s     = 1'b0;
            rd_s     = 1'b0;
            ptr_ld   = 1'b0;
            ptr_inc  = 1'b0;
            d.oe     = 1'b0;
            d.bcnt   = '0;
            d.ptr_ph = 1'b1;
            d.st     = start_w ? ST_HDR : ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, bcnt: '0, sh: '0, oe: 1'b0, ptr_ph: 1'b1,
                   rtc: 1'b0, rnw: 1'b0, more: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign sda_oe    = q.oe;
    assign reg_wr    = wr_s;
    assign reg_rd    = rd_s;
    assign reg_space = q.rtc;
    assign reg_addr  = ptr_all[q.rtc];
    assign reg_wdata = q.sh;

endmodule

// File: rtl/dsit_checker.sv
module dsit_checker (
    input logic clk,
    input logic rst_n,
    input logic sda_oe,
    input logic reg_wr,
    input logic reg_rd,
    input logic scl_fall,
    input logic start_det,
    input logic stop_det,
    input logic ptr_ph
);

    // R6: a read strobe lasts a single cycle
    a_r6_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);

    // R2, R3: a write strobe lasts a single cycle
    a_r2_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    // R7: read and write strobes never coincide
    a_r7_no_clash: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_wr));

    // R1: SDA drive changes only after a detected SCL fall or bus condition
    a_r1_oe_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));

    // R4: STOP restores the pointer/address byte phase
    a_r4_stop_parity: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> ptr_ph);

    // R4: START and repeated START restore the pointer/address byte phase
    a_r4_start_parity: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> ptr_ph);

endmodule

bind dual_space_i2c_target dsit_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe    (sda_oe),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .scl_fall  (scl_fall_w),
    .start_det (start_w),
    .stop_det  (stop_w),
    .ptr_ph    (q.ptr_ph)
);

// File: tb/dual_space_i2c_target_bench.sv
`timescale 1ns/1ps
module dual_space_i2c_target_bench;

    localparam logic [6:0] PWR = 7'h1C;
    localparam logic [6:0] RTC = 7'h48;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_drv = 1'b1;
    logic sda_drv = 1'b1;
    logic sda_oe, reg_wr, reg_rd, reg_space;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic sda_line;

    int n_checks = 0;
    int n_errs   = 0;
    int wr_cnt   = 0;
    int rd_cnt   = 0;
    logic [7:0] pwr_m [256];
    logic [7:0] rtc_m [256];

    always #5 clk = ~clk;

    assign sda_line  = sda_drv & ~sda_oe;
    assign reg_rdata = reg_space ? rtc_m[reg_addr] : pwr_m[reg_addr];

    dual_space_i2c_target u_dual_space_i2c_target (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_drv),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_space (reg_space),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    function automatic logic [7:0] pwr_init(input int i);
        return 8'(i) ^ 8'h5A;
    endfunction

    function automatic logic [7:0] rtc_init(input int i);
        return 8'(i * 7 + 3);
    endfunction

    // register model: status at clock-space 0x00 clears when read
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) begin
                pwr_m[i] <= pwr_init(i);
                rtc_m[i] <= rtc_init(i);
            end
        end else begin
            if (reg_wr) begin
                if (reg_space) rtc_m[reg_addr] <= reg_wdata;
                else           pwr_m[reg_addr] <= reg_wdata;
                wr_cnt <= wr_cnt + 1;
            end
            if (reg_rd) begin
                rd_cnt <= rd_cnt + 1;
                if (reg_space && reg_addr == 8'h00) rtc_m[0] <= 8'h00;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        waitc(Q/2); sda_drv = 1'b1;
        waitc(Q);   scl_drv = 1'b1;
        waitc(Q);   sda_drv = 1'b0;
        waitc(Q);   scl_drv = 1'b0;
    endtask

    task automatic bus_stop();
        waitc(Q/2); sda_drv = 1'b0;
        waitc(Q);   scl_drv = 1'b1;
        waitc(Q);   sda_drv = 1'b1;
        waitc(Q);
    endtask

    task automatic bus_bit(input logic b, output logic s);
        waitc(Q/2); sda_drv = b;
        waitc(Q);   scl_drv = 1'b1;
        waitc(Q);   s = sda_line;
        waitc(Q);   scl_drv = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic nack);
        logic s;
        for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
        bus_bit(1'b1, nack);
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        logic s;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            bus_bit(1'b1, s);
            b = {b[6:0], s};
        end
        bus_bit(nack, s);
    endtask

    task automatic t_reset();
        logic a;
        logic [7:0] v;
        chk("R9 sda_oe after reset", int'(sda_oe), 0);
        chk("R9 no write strobe after reset", wr_cnt, 0);
        chk("R9 no read strobe after reset", rd_cnt, 0);
        bus_start();
        send_byte({RTC, 1'b1}, a);
        chk("R9 rtc read header ack", int'(a), 0);
        recv_byte(1'b1, v);
        bus_stop();
        chk("R9 first read starts at 0x00", int'(v), int'(rtc_init(0)));
    endtask

    task automatic t_addr();
        logic a;
        int w0;
        w0 = wr_cnt;
        bus_start();
        send_byte({7'h33, 1'b0}, a);
        chk("R1 foreign address nacked", int'(a), 1);
        send_byte(8'h00, a);
        chk("R1 byte after nack not acked", int'(a), 1);
        send_byte(8'h99, a);
        bus_stop();
        chk("R1 no write strobe after nack", wr_cnt, w0);
        chk("R1 power model untouched", int'(pwr_m[0]), int'(pwr_init(0)));
        bus_start();
        send_byte({PWR, 1'b0}, a);
        chk("R1 power address acked", int'(a), 0);
        bus_stop();
        bus_start();
        send_byte({RTC, 1'b0}, a);
        chk("R1 rtc address acked", int'(a), 0);
        bus_stop();
    endtask

    task automatic t_rtc_write();
        logic a;
        int w0, nk;
        w0 = wr_cnt;
        nk = 0;
        bus_start();
        send_byte({RTC, 1'b0}, a);
        send_byte(8'h20, a); nk += int'(a);
        send_byte(8'h11, a); nk += int'(a);
        send_byte(8'h22, a); nk += int'(a);
        send_byte(8'h33, a); nk += int'(a);
        bus_stop();
        chk("R7 rtc data bytes acked", nk, 0);
        chk("R2 three write strobes", wr_cnt - w0, 3);
        chk("R2 rtc 0x20", int'(rtc_m[8'h20]), 'h11);
        chk("R2 rtc 0x21", int'(rtc_m[8'h21]), 'h22);
        chk("R2 rtc 0x22", int'(rtc_m[8'h22]), 'h33);
        chk("R2 power space untouched", int'(pwr_m[8'h20]), int'(pwr_init('h20)));
    endtask

    task automatic t_pwr_pair();
        logic a;
        int nk;
        nk = 0;
        bus_start();
        send_byte({PWR, 1'b0}, a);
        send_byte(8'h30, a); nk += int'(a);
        send_byte(8'hAA, a); nk += int'(a);
        send_byte(8'h35, a); nk += int'(a);
        send_byte(8'hBB, a); nk += int'(a);
        bus_stop();
        chk("R7 power bytes acked", nk, 0);
        chk("R3 pair write 0x30", int'(pwr_m[8'h30]), 'hAA);
        chk("R3 pair write 0x35", int'(pwr_m[8'h35]), 'hBB);
        chk("R3 gap 0x31 untouched", int'(pwr_m[8'h31]), int'(pwr_init('h31)));
        chk("R3 rtc space untouched", int'(rtc_m[8'h30]), int'(rtc_init('h30)));
    endtask

    task automatic t_parity();
        logic a;
        bus_start();
        send_byte({PWR, 1'b0}, a);
        send_byte(8'h40, a);
        send_byte(8'hC1, a);
        send_byte(8'h41, a);
        bus_stop();
        bus_start();
        send_byte({PWR, 1'b0}, a);
        send_byte(8'h42, a);
        send_byte(8'hD2, a);
        bus_stop();
        chk("R4 stop resets parity 0x42", int'(pwr_m[8'h42]), 'hD2);
        chk("R4 dangling 0x41 untouched", int'(pwr_m[8'h41]), int'(pwr_init('h41)));
        bus_start();
        send_byte({PWR, 1'b0}, a);
        send_byte(8'h50, a);
        bus_start();
        send_byte({PWR, 1'b0}, a);
        send_byte(8'h51, a);
        send_byte(8'hE5, a);
        bus_stop();
        chk("R4 repeated start resets parity 0x51", int'(pwr_m[8'h51]), 'hE5);
        chk("R4 0x50 untouched", int'(pwr_m[8'h50]), int'(pwr_init('h50)));
    endtask

    task automatic t_read();
        logic a;
        logic [7:0] v0, v1, v2;
        int r0;
        bus_start();
        send_byte({RTC, 1'b0}, a);
        send_byte(8'h20, a);
        bus_start();
        send_byte({RTC, 1'b1}, a);
        r0 = rd_cnt;
        recv_byte(1'b0, v0);
        recv_byte(1'b0, v1);
        recv_byte(1'b1, v2);
        bus_stop();
        chk("R5 rtc read byte 0", int'(v0), 'h11);
        chk("R5 rtc read byte 1", int'(v1), 'h22);
        chk("R5 rtc read byte 2", int'(v2), 'h33);
        chk("R6 three read strobes", rd_cnt - r0, 3);
        bus_start();
        send_byte({RTC, 1'b1}, a);
        recv_byte(1'b1, v0);
        bus_stop();
        chk("R5 pointer continues at 0x23", int'(v0), int'(rtc_init('h23)));
        bus_start();
        send_byte({PWR, 1'b0}, a);
        send_byte(8'h10, a);
        bus_start();
        send_byte({PWR, 1'b1}, a);
        r0 = rd_cnt;
        recv_byte(1'b0, v0);
        recv_byte(1'b1, v1);
        bus_stop();
        chk("R5 power read 0x10", int'(v0), int'(pwr_init('h10)));
        chk("R5 power read 0x11", int'(v1), int'(pwr_init('h11)));
        chk("R6 two read strobes", rd_cnt - r0, 2);
    endtask

    task automatic t_clear_once();
        logic a;
        logic [7:0] v0, v1;
        bus_start();
        send_byte({RTC, 1'b0}, a);
        send_byte(8'h00, a);
        send_byte(8'h13, a);
        bus_stop();
        bus_start();
        send_byte({RTC, 1'b0}, a);
        send_byte(8'h00, a);
        bus_start();
        send_byte({RTC, 1'b1}, a);
        recv_byte(1'b1, v0);
        bus_stop();
        bus_start();
        send_byte({RTC, 1'b0}, a);
        send_byte(8'h00, a);
        bus_start();
        send_byte({RTC, 1'b1}, a);
        recv_byte(1'b0, v0);
        recv_byte(1'b1, v1);
        bus_stop();
        chk("R6 status cleared by single read", int'(v0), 0);
        chk("R6 mask register follows status", int'(v1), int'(rtc_init(1)));
    endtask

    task automatic t_separate();
        logic a;
        logic [7:0] v;
        bus_start();
        send_byte({RTC, 1'b0}, a);
        send_byte(8'h05, a);
        bus_stop();
        bus_start();
        send_byte({PWR, 1'b0}, a);
        send_byte(8'h06, a);
        send_byte(8'h77, a);
        bus_stop();
        bus_start();
        send_byte({RTC, 1'b1}, a);
        recv_byte(1'b1, v);
        bus_stop();
        chk("R8 rtc pointer kept across power access", int'(v), int'(rtc_init(5)));
        chk("R8 power write landed", int'(pwr_m[8'h06]), 'h77);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        waitc(5);
        rst_n = 1'b1;
        waitc(5);
        t_reset();
        t_addr();
        t_rtc_write();
        t_pwr_pair();
        t_parity();
        t_read();
        t_clear_once();
        t_separate();
        waitc(10);
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

endmodule